// File: doc/BRIEF.md
# Pilot-Aided Frame Assembler

This block builds fixed-length transmit frames for a coded satellite burst. Each frame starts with a header. The header is a 128-symbol marker followed by a 128-symbol acquisition field. Twenty sub-blocks follow it, and each sub-block is a pilot field followed by 405 payload symbols, for 8100 payload symbols per frame. One more pilot field closes the frame. The receiver uses the pilot fields to pre-compensate phase across the long codeword, so the pilot field is longer for the lowest-order modulation than for the others.

Payload symbols come from an upstream mapper over a valid/ready stream and are pulled only while a payload field is in progress. Header and pilot symbols are produced internally from fixed, index-derived sequences. The block emits every symbol from a register stage, together with a field tag and a start-of-frame pulse. A frame is requested with a level input. The modulation mode is sampled when the frame starts. Frames run back to back for as long as the request stays high.

Top module: `pilot_frame_assembler`

## Requirements
- R1: After reset, and whenever no frame is in progress, `out_valid`, `out_sof` and `in_ready` are low. Payload offered on the input while idle is not taken.
- R2: In the idle state, `frame_go` is sampled high on a rising edge. The first marker symbol is then registered on the next rising edge, so it is visible one cycle after the sampling edge.
- R3: The header has two parts, all tagged `out_tag`=0. First come 128 marker symbols, where marker symbol k has the value 0xA5 XOR k. Then come 128 acquisition symbols, with the value 0x33 at even positions and 0xCC at odd positions.
- R4: After the header come 20 sub-blocks. Each one is a pilot field (`out_tag`=1) followed by exactly 405 payload symbols (`out_tag`=2).
- R5: Pilot field length follows the mode. Mode code 0 (QPSK) gives 18 symbols, and every other code 1..7 gives 12 symbols. Pilot symbol j of any field has the value 0x96 XOR j.
- R6: A trailing pilot field of the same length follows the 20th payload field. It makes the frame 8734 symbols long for mode 0 and 8608 symbols long otherwise.
- R7: The mode is captured when a frame starts, and changes on `mode_sel` during the frame have no effect on that frame.
- R8: `in_ready` is high only during payload fields. Each accepted input symbol appears on the output on the next cycle, tagged 2, with nothing reordered, dropped or repeated. An input stall gives a cycle with `out_valid` low.
- R9: Header and pilot symbols are emitted on consecutive cycles without gaps. A frame with no input stalls occupies exactly its length in cycles.
- R10: If `frame_go` is high when the last trailing pilot symbol is sequenced, the next frame's marker follows with no gap. Otherwise the block returns to idle.
- R11: `out_sof` is high exactly with the first marker symbol of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Frame request level, sampled at frame boundaries |
| mode_sel | input | 3 | Modulation code for the next frame, 0 = QPSK |
| in_valid | input | 1 | Payload symbol valid |
| in_ready | output | 1 | Payload symbol accepted when high with in_valid |
| in_sym | input | 8 | Payload symbol from the mapper |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | 8 | Output symbol |
| out_tag | output | 2 | Field tag: 0 header, 1 pilot, 2 payload |
| out_sof | output | 1 | First symbol of a frame |

## Verification
Some properties are checked by assertions on every cycle. Each accepted payload symbol must appear on the next cycle with its value intact, and no payload output may appear without a handshake. The start pulse must coincide with the first marker value, and the header must never break. Every pilot run must be 12 or 18 symbols, and every payload run must be exactly 405 symbols.

Other behaviours need whole frames to show: the field order, the exact header and pilot values, the trailing pilot field, the total frame length and the mode latch. The bench scenarios cover these, with modes changed mid-frame, several input stall patterns, back-to-back frames and a reset in mid-frame.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

  typedef enum logic [1:0] {
    TAG_HDR  = 2'd0,
    TAG_PIL  = 2'd1,
    TAG_DATA = 2'd2
  } field_tag_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MARK = 3'd1,
    ST_ACQ  = 3'd2,
    ST_PIL  = 3'd3,
    ST_DATA = 3'd4
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfa_sequencer.sv
module pfa_sequencer
  import pfa_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int IDX_W     = 9,
  parameter int MARK_LEN  = 128,
  parameter int ACQ_LEN   = 128,
  parameter int NUM_SUB   = 20,
  parameter int SUB_LEN   = 405,
  parameter int PIL_LONG  = 18,
  parameter int PIL_SHORT = 12,
  parameter int QPSK_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_go,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              in_valid,
  output seq_state_t        state,
  output logic [IDX_W-1:0]  idx,
  output logic              emit,
  output logic              sof_sym,
  output logic              in_ready
);

  localparam int SUB_W = $clog2(NUM_SUB + 1);
  localparam logic [IDX_W-1:0] MARK_LAST = IDX_W'(MARK_LEN - 1);
  localparam logic [IDX_W-1:0] ACQ_LAST  = IDX_W'(ACQ_LEN - 1);
  localparam logic [IDX_W-1:0] SUB_LAST  = IDX_W'(SUB_LEN - 1);
  localparam logic [IDX_W-1:0] PLEN_L    = IDX_W'(PIL_LONG);
  localparam logic [IDX_W-1:0] PLEN_S    = IDX_W'(PIL_SHORT);
  localparam logic [SUB_W-1:0] SUB_TRAIL = SUB_W'(NUM_SUB);
  localparam logic [SUB_W-1:0] SUB_FINAL = SUB_W'(NUM_SUB - 1);
  localparam logic [MODE_W-1:0] QPSK_M   = MODE_W'(QPSK_CODE);

  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] pil_len_q;
  logic [IDX_W-1:0] pil_pick;
  logic             pil_end;

  // Pilot length chosen from the mode presented at frame start.
  assign pil_pick = (mode_sel == QPSK_M) ? PLEN_L : PLEN_S;
  assign pil_end  = (idx == pil_len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      sub_q     <= '0;
      pil_len_q <= PLEN_L;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frame_go) begin
            state     <= ST_MARK;
            idx       <= '0;
            sub_q     <= '0;
            pil_len_q <= pil_pick;
          end
        end
        ST_MARK: begin
          if (idx == MARK_LAST) begin
            state <= ST_ACQ;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_ACQ: begin
          if (idx == ACQ_LAST) begin
            state <= ST_PIL;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PIL: begin
          if (pil_end) begin
            idx <= '0;
            if (sub_q == SUB_TRAIL) begin
              // Trailing pilot finished: chain the next frame or rest.
              sub_q <= '0;
              if (frame_go) begin
                state     <= ST_MARK;
                pil_len_q <= pil_pick;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_DATA;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            if (idx == SUB_LAST) begin
              state <= ST_PIL;
              idx   <= '0;
              sub_q <= (sub_q == SUB_FINAL) ? SUB_TRAIL : sub_q + 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          idx   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    in_ready = (state == ST_DATA);
    sof_sym  = (state == ST_MARK) && (idx == '0);
    case (state)
      ST_MARK, ST_ACQ, ST_PIL: emit = 1'b1;
      ST_DATA:                 emit = in_valid;
      default:                 emit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pfa_symbol_gen.sv
module pfa_symbol_gen
  import pfa_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int IDX_W = 9,
  parameter logic [SYM_W-1:0] MARK_KEY = 'hA5,
  parameter logic [SYM_W-1:0] PIL_KEY  = 'h96,
  parameter logic [SYM_W-1:0] ACQ_EVEN = 'h33,
  parameter logic [SYM_W-1:0] ACQ_ODD  = 'hCC
) (
  input  seq_state_t       state,
  input  logic [IDX_W-1:0] idx,
  input  logic [SYM_W-1:0] in_sym,
  output logic [SYM_W-1:0] sym,
  output field_tag_t       tag
);

  logic [SYM_W-1:0] idx_s;

  // Position index brought to the symbol width.
  generate
    if (IDX_W >= SYM_W) begin : g_trunc
      assign idx_s = SYM_W'(idx);
    end else begin : g_ext
      assign idx_s = {{(SYM_W - IDX_W){1'b0}}, idx};
    end
  endgenerate

  always_comb begin
    case (state)
      ST_MARK: begin
        sym = MARK_KEY ^ idx_s;
        tag = TAG_HDR;
      end
      ST_ACQ: begin
        sym = idx_s[0] ? ACQ_ODD : ACQ_EVEN;
        tag = TAG_HDR;
      end
      ST_PIL: begin
        sym = PIL_KEY ^ idx_s;
        tag = TAG_PIL;
      end
      ST_DATA: begin
        sym = in_sym;
        tag = TAG_DATA;
      end
      default: begin
        sym = '0;
        tag = TAG_HDR;
      end
    endcase
  end

endmodule

// File: rtl/pfa_out_stage.sv
module pfa_out_stage
  import pfa_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic             sof_sym,
  input  logic [SYM_W-1:0] sym,
  input  field_tag_t       tag,
  output logic             out_valid,
  output logic             out_sof,
  output logic [SYM_W-1:0] out_sym,
  output logic [1:0]       out_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sym   <= '0;
      out_tag   <= TAG_HDR;
    end else begin
      out_valid <= emit;
      out_sof   <= emit && sof_sym;
      if (emit) begin
        out_sym <= sym;
        out_tag <= tag;
      end
    end
  end

endmodule

// File: rtl/pilot_frame_assembler.sv
module pilot_frame_assembler
  import pfa_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int MODE_W    = 3,
  parameter int MARK_LEN  = 128,
  parameter int ACQ_LEN   = 128,
  parameter int NUM_SUB   = 20,
  parameter int SUB_LEN   = 405,
  parameter int PIL_LONG  = 18,
  parameter int PIL_SHORT = 12,
  parameter int QPSK_CODE = 0,
  parameter logic [SYM_W-1:0] MARK_KEY = 'hA5,
  parameter logic [SYM_W-1:0] PIL_KEY  = 'h96,
  parameter logic [SYM_W-1:0] ACQ_EVEN = 'h33,
  parameter logic [SYM_W-1:0] ACQ_ODD  = 'hCC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_go,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYM_W-1:0]  in_sym,
  output logic              out_valid,
  output logic [SYM_W-1:0]  out_sym,
  output logic [1:0]        out_tag,
  output logic              out_sof
);

  localparam int MAX_FIELD = max_of(max_of(MARK_LEN, ACQ_LEN),
                                    max_of(SUB_LEN, max_of(PIL_LONG, PIL_SHORT)));
  localparam int IDX_W     = $clog2(MAX_FIELD + 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             emit;
  logic             sof_sym;
  logic [SYM_W-1:0] sym;
  field_tag_t       tag;

  pfa_sequencer #(
    .MODE_W    (MODE_W),
    .IDX_W     (IDX_W),
    .MARK_LEN  (MARK_LEN),
    .ACQ_LEN   (ACQ_LEN),
    .NUM_SUB   (NUM_SUB),
    .SUB_LEN   (SUB_LEN),
    .PIL_LONG  (PIL_LONG),
    .PIL_SHORT (PIL_SHORT),
    .QPSK_CODE (QPSK_CODE)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .frame_go (frame_go),
    .mode_sel (mode_sel),
    .in_valid (in_valid),
    .state    (state),
    .idx      (idx),
    .emit     (emit),
    .sof_sym  (sof_sym),
    .in_ready (in_ready)
  );

  pfa_symbol_gen #(
    .SYM_W    (SYM_W),
    .IDX_W    (IDX_W),
    .MARK_KEY (MARK_KEY),
    .PIL_KEY  (PIL_KEY),
    .ACQ_EVEN (ACQ_EVEN),
    .ACQ_ODD  (ACQ_ODD)
  ) i_symgen (
    .state  (state),
    .idx    (idx),
    .in_sym (in_sym),
    .sym    (sym),
    .tag    (tag)
  );

  pfa_out_stage #(
    .SYM_W (SYM_W)
  ) i_out (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .sof_sym   (sof_sym),
    .sym       (sym),
    .tag       (tag),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sym   (out_sym),
    .out_tag   (out_tag)
  );

endmodule

// File: rtl/pfa_checker.sv
module pfa_checker #(
  parameter int SYM_W     = 8,
  parameter int SUB_LEN   = 405,
  parameter int PIL_LONG  = 18,
  parameter int PIL_SHORT = 12,
  parameter logic [SYM_W-1:0] MARK_KEY = 'hA5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SYM_W-1:0] in_sym,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_sym,
  input logic [1:0]       out_tag,
  input logic             out_sof
);

  int   pil_run;
  int   data_run;
  logic prev_pil;
  logic prev_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pil_run   <= 0;
      data_run  <= 0;
      prev_pil  <= 1'b0;
      prev_data <= 1'b0;
    end else if (out_valid) begin
      pil_run   <= (out_tag == 2'd1) ? (prev_pil ? pil_run + 1 : 1) : 0;
      data_run  <= (out_tag == 2'd2) ? (prev_data ? data_run + 1 : 1) : 0;
      prev_pil  <= (out_tag == 2'd1);
      prev_data <= (out_tag == 2'd2);
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sof));

  assert_data_follows_handshake_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_tag == 2'd2 && out_sym == $past(in_sym)));

  assert_data_needs_handshake_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == 2'd2) |-> $past(in_valid && in_ready));

  assert_sof_on_marker_R11: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_valid && out_tag == 2'd0 && out_sym == MARK_KEY));

  assert_header_unbroken_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == 2'd0) |=> out_valid);

  assert_pilot_len_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag != 2'd1 && prev_pil) |-> (pil_run == PIL_SHORT || pil_run == PIL_LONG));

  assert_sub_len_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag != 2'd2 && prev_data) |-> (data_run == SUB_LEN));

  assert_sub_bound_R4: assert property (@(posedge clk) disable iff (rst)
    data_run <= SUB_LEN);

endmodule

bind pilot_frame_assembler pfa_checker #(
  .SYM_W     (SYM_W),
  .SUB_LEN   (SUB_LEN),
  .PIL_LONG  (PIL_LONG),
  .PIL_SHORT (PIL_SHORT),
  .MARK_KEY  (MARK_KEY)
) u_pfa_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sym    (in_sym),
  .out_valid (out_valid),
  .out_sym   (out_sym),
  .out_tag   (out_tag),
  .out_sof   (out_sof)
);

// File: tb/test_pilot_frame_assembler.sv
module test_pilot_frame_assembler;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_go = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_sym = 8'd0;
  logic       out_valid;
  logic [7:0] out_sym;
  logic [1:0] out_tag;
  logic       out_sof;

  always #2 clk = ~clk;  // 250 MHz

  pilot_frame_assembler i_pilot_frame_assembler (
    .clk(clk), .rst(rst), .frame_go(frame_go), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_sym(out_sym), .out_tag(out_tag), .out_sof(out_sof)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Stimulus table: [27:25] mode at start, [24:22] mode written mid-frame,
  // [21:14] input stall mask over cyc%8, [13:0] expected frame length.
  localparam logic [27:0] VEC [5] = '{
    {3'd0, 3'd3, 8'h00, 14'd8734},
    {3'd2, 3'd0, 8'h00, 14'd8608},
    {3'd4, 3'd4, 8'h55, 14'd8608},
    {3'd0, 3'd0, 8'h81, 14'd8734},
    {3'd7, 3'd0, 8'h0F, 14'd8608}
  };

  // Payload driver
  bit       drv_en = 0;
  logic [7:0] cur_mask = 8'h00;
  int       dctr = 0;

  initial begin
    forever begin
      @(negedge clk);
      in_valid = drv_en && !cur_mask[cyc[2:0]];
      in_sym   = dctr[7:0];
      if (in_valid && in_ready) dctr++;
    end
  end

  // Monitor with independent frame model
  int exp_plen = 18;
  int flen = 8734;
  int mon_pos = 0;
  int data_exp = 0;
  int frames_done = 0;
  int err_hdr = 0, err_pil = 0, err_trail = 0, err_data = 0, err_sof = 0;
  int last_act = 0, last_exp = 0;
  int sof_cycle = 0, last_cycle = 0, gap_at_sof = 0;

  function automatic void exp_at(input int pos, input int plen,
                                 output logic [1:0] t, output logic [7:0] s,
                                 output bit is_data);
    int blk, p, r, k;
    is_data = 0;
    if (pos < 128) begin
      t = 2'd0; k = pos; s = 8'hA5 ^ k[7:0];
    end else if (pos < 256) begin
      t = 2'd0; s = pos[0] ? 8'hCC : 8'h33;
    end else begin
      blk = plen + 405;
      p = pos - 256;
      r = p % blk;
      if (r < plen) begin
        t = 2'd1; s = 8'h96 ^ r[7:0];
      end else begin
        t = 2'd2; s = 8'h00; is_data = 1;
      end
    end
  endfunction

  always @(negedge clk) begin
    logic [1:0] et;
    logic [7:0] es;
    bit         ed;
    if (rst) begin
      mon_pos = 0;
    end else if (out_valid) begin
      exp_at(mon_pos, exp_plen, et, es, ed);
      if (ed) es = data_exp[7:0];
      if (out_tag !== et || out_sym !== es) begin
        last_act = {22'd0, out_tag, out_sym};
        last_exp = {22'd0, et, es};
        if (mon_pos < 256) err_hdr++;
        else if (ed) err_data++;
        else if (mon_pos >= flen - exp_plen) err_trail++;
        else err_pil++;
      end
      if (out_sof !== (mon_pos == 0)) err_sof++;
      if (mon_pos == 0) begin
        gap_at_sof = cyc - last_cycle;
        sof_cycle = cyc;
      end
      if (ed) data_exp++;
      mon_pos++;
      if (mon_pos == flen) begin
        mon_pos = 0;
        frames_done++;
        last_cycle = cyc;
      end
    end
  end

  task automatic idle_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid || in_ready || out_sof) seen++;
    end
    check(seen == 0, req, "activity while idle", seen, 0);
  endtask

  task automatic frame_checks(input int h0, input int p0, input int t0, input int d0,
                              input int s0, input string pil_req);
    check(err_hdr == h0, "R3", "header symbol mismatches", err_hdr - h0, 0);
    if (err_hdr != h0) $display("  last mismatch actual=%0h expected=%0h", last_act, last_exp);
    check(err_pil == p0, pil_req, "pilot/sub-block layout mismatches", err_pil - p0, 0);
    check(err_trail == t0, "R6", "trailing pilot mismatches", err_trail - t0, 0);
    check(err_data == d0, "R8", "payload order mismatches", err_data - d0, 0);
    check(err_sof == s0, "R11", "start pulse mismatches", err_sof - s0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    check(out_sof == 1'b0, "R11", "out_sof in reset", out_sof, 0);
    rst = 1'b0;

    // R1: payload offered while idle is ignored
    drv_en = 1;
    idle_quiet("R1", 20);
    check(dctr == 0, "R1", "symbols taken while idle", dctr, 0);
    drv_en = 0;

    // Table walk
    for (int e = 0; e < 5; e++) begin
      int base, h0, p0, t0, d0, s0;
      logic [2:0] ms, mm;
      logic [7:0] mask;
      ms = VEC[e][27:25];
      mm = VEC[e][24:22];
      mask = VEC[e][21:14];
      flen = int'(VEC[e][13:0]);
      exp_plen = (ms == 3'd0) ? 18 : 12;
      base = frames_done;
      h0 = err_hdr; p0 = err_pil; t0 = err_trail; d0 = err_data; s0 = err_sof;
      @(negedge clk);
      cur_mask = mask; drv_en = 1; mode_sel = ms; frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
      check(out_valid == 1'b0, "R2", "output before first marker edge", out_valid, 0);
      @(negedge clk);
      check(out_sof == 1'b1 && out_tag == 2'd0, "R2", "first marker after one cycle",
            {out_sof, out_tag}, 4);
      repeat (300) @(negedge clk);
      mode_sel = mm;  // R7: must not alter this frame
      while (frames_done == base) @(negedge clk);
      frame_checks(h0, p0, t0, d0, s0, (mm != ms) ? "R7" : "R5");
      if (mask == 8'h00)
        check(last_cycle - sof_cycle == flen - 1, "R9", "unstalled frame cycles",
              last_cycle - sof_cycle + 1, flen);
      drv_en = 0;
      idle_quiet("R10", 10);
    end

    // R10: back-to-back frames with no gap
    begin
      int base, h0, p0, t0, d0, s0;
      flen = 8608; exp_plen = 12;
      base = frames_done;
      h0 = err_hdr; p0 = err_pil; t0 = err_trail; d0 = err_data; s0 = err_sof;
      @(negedge clk);
      cur_mask = 8'h00; drv_en = 1; mode_sel = 3'd1; frame_go = 1'b1;
      while (frames_done == base) @(negedge clk);
      frame_go = 1'b0;
      while (frames_done == base + 1) @(negedge clk);
      check(gap_at_sof == 1, "R10", "cycles from last trailing pilot to next marker",
            gap_at_sof, 1);
      frame_checks(h0, p0, t0, d0, s0, "R4");
      drv_en = 0;
      idle_quiet("R10", 10);
    end

    // R1: reset in the middle of a frame returns to idle
    @(negedge clk);
    mode_sel = 3'd0; frame_go = 1'b1; exp_plen = 18; flen = 8734;
    @(negedge clk);
    frame_go = 1'b0;
    repeat (60) @(negedge clk);
    check(out_valid == 1'b1, "R9", "header streaming before reset", out_valid, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1", "outputs after mid-frame reset",
          {out_valid, in_ready}, 0);
    rst = 1'b0;
    idle_quiet("R1", 10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", frames_done, 7);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule